// File: doc/BRIEF.md
# Lockable Transfer Mode Register

This block holds three mode bits that shape how bytes move between a host and a disk-controller data path. The first bit turns burst transfers off. The second makes host reads bypass the internal queue. The third makes host writes bypass it. The register does not just store these bits. It combines them with a global queue-enable setting and with the direction of the current transfer. From these it drives effective control signals: whether the queue is used for reads, whether it is used for writes, whether burst is active, whether the current transfer goes through the queue, and whether each byte needs its own request pulse.

A separate lock bit protects the three mode bits against a soft reset. A hard reset clears everything, including the lock. While the global queue is disabled, the stored mode bits are not consulted at all. The outputs then report bypass and non-burst operation, and the stored values come back into force once the queue is enabled again. The queue storage and the DMA engine sit outside this block.

Top module: `xfer_mode_reg`

## Requirements
- R1: While `rstN` is low the three mode bits and the lock are 0. With `fifoEnable`=1 this gives `useFifoRd`=1, `useFifoWr`=1 and `burstMode`=1.
- R2: A write with `cfgWrEn`=1 loads `cfgWrData` into the mode bits at the next rising clock edge. Bit 0 means burst off, bit 1 means read bypass and bit 2 means write bypass.
- R3: A `softReset` while the lock is 0 clears all three mode bits at the next edge.
- R4: A `softReset` while the lock is 1 leaves the mode bits unchanged.
- R5: When `softReset` and `cfgWrEn` are high in the same cycle, the write is discarded.
- R6: A hard reset clears the lock as well. After it, a soft reset clears the mode bits again.
- R7: While `fifoEnable`=0, `useFifoRd`, `useFifoWr` and `burstMode` are all 0 whatever the mode bits hold. The stored bits are kept and return to effect when `fifoEnable` goes back to 1.
- R8: `useFifoRd` = `fifoEnable` & !bit1 and `useFifoWr` = `fifoEnable` & !bit2. `fifoActive` follows `useFifoRd` when `xferRead`=1 and follows `useFifoWr` otherwise.
- R9: `burstMode` = `fifoEnable` & !bit0. `perByteReq` is 1 exactly when the current transfer bypasses the queue or burst is off.
- R10: A `lockWrEn` loads `lockWrData` into the lock at the next edge. A soft reset leaves the lock unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous hard reset, active low |
| softReset | input | 1 | Synchronous soft reset |
| cfgWrEn | input | 1 | Mode register write strobe |
| cfgWrData | input | 3 | Mode bits: [0] burst off, [1] read bypass, [2] write bypass |
| lockWrEn | input | 1 | Lock write strobe |
| lockWrData | input | 1 | New lock value |
| fifoEnable | input | 1 | Global queue enable |
| xferRead | input | 1 | 1 = current transfer is a host read, 0 = host write |
| useFifoRd | output | 1 | Reads use the queue |
| useFifoWr | output | 1 | Writes use the queue |
| burstMode | output | 1 | Burst transfers active |
| fifoActive | output | 1 | Current transfer goes through the queue |
| perByteReq | output | 1 | One request pulse per byte is needed |

## Verification
The checker assumes that every strobe is a clean level sampled on the rising edge. It also assumes that `rstN` is the only asynchronous input, so the effective outputs can be compared combinationally at any clocked sample. The bench drives every input at the falling edge and samples one nanosecond later. Strobes therefore never change near the active edge. The sweep covers all eight mode values against both queue-enable settings and both directions. Soft reset, lock and write collisions are then driven one at a time, so each effect is tied to a single edge.

// File: rtl/xfer_mode_pkg.sv
package xfer_mode_pkg;
  localparam int MODE_W = 3;

  typedef struct packed {
    logic wrOff;
    logic rdOff;
    logic burstOff;
  } mode_t;

  typedef struct packed {
    logic clrModes;
    logic loadModes;
    logic loadLock;
  } strobe_t;

  localparam mode_t MODE_DEFAULT = '{wrOff: 1'b0, rdOff: 1'b0, burstOff: 1'b0};
endpackage

// File: rtl/xfer_mode_ctrl.sv
module xfer_mode_ctrl
  import xfer_mode_pkg::*;
(
  input  logic    softReset,
  input  logic    cfgWrEn,
  input  logic    lockWrEn,
  input  logic    lockQ,
  output strobe_t strobes
);
  always_comb begin
    strobes = '0;
    // soft reset wins over a write in the same cycle
    strobes.clrModes  = softReset & ~lockQ;
    strobes.loadModes = cfgWrEn & ~softReset;
    strobes.loadLock  = lockWrEn;
  end
endmodule

// File: rtl/xfer_mode_dp.sv
module xfer_mode_dp
  import xfer_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [MODE_W-1:0] cfgWrData,
  input  logic              lockWrData,
  input  logic              fifoEnable,
  input  logic              xferRead,
  output mode_t             modeQ,
  output logic              lockQ,
  output logic              useFifoRd,
  output logic              useFifoWr,
  output logic              burstMode,
  output logic              fifoActive,
  output logic              perByteReq
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_DEFAULT;
      lockQ <= 1'b0;
    end else begin
      if (strobes.clrModes)       modeQ <= MODE_DEFAULT;
      else if (strobes.loadModes) modeQ <= mode_t'(cfgWrData);
      if (strobes.loadLock)       lockQ <= lockWrData;
    end
  end

  always_comb begin
    useFifoRd  = fifoEnable & ~modeQ.rdOff;
    useFifoWr  = fifoEnable & ~modeQ.wrOff;
    burstMode  = fifoEnable & ~modeQ.burstOff;
    fifoActive = xferRead ? useFifoRd : useFifoWr;
    perByteReq = ~(fifoActive & burstMode);
  end
endmodule

// File: rtl/xfer_mode_reg.sv
module xfer_mode_reg
  import xfer_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              softReset,
  input  logic              cfgWrEn,
  input  logic [MODE_W-1:0] cfgWrData,
  input  logic              lockWrEn,
  input  logic              lockWrData,
  input  logic              fifoEnable,
  input  logic              xferRead,
  output logic              useFifoRd,
  output logic              useFifoWr,
  output logic              burstMode,
  output logic              fifoActive,
  output logic              perByteReq
);
  strobe_t strobes;
  mode_t   modeQ;
  logic    lockQ;

  xfer_mode_ctrl u_ctrl (
    .softReset (softReset),
    .cfgWrEn   (cfgWrEn),
    .lockWrEn  (lockWrEn),
    .lockQ     (lockQ),
    .strobes   (strobes)
  );

  xfer_mode_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgWrData  (cfgWrData),
    .lockWrData (lockWrData),
    .fifoEnable (fifoEnable),
    .xferRead   (xferRead),
    .modeQ      (modeQ),
    .lockQ      (lockQ),
    .useFifoRd  (useFifoRd),
    .useFifoWr  (useFifoWr),
    .burstMode  (burstMode),
    .fifoActive (fifoActive),
    .perByteReq (perByteReq)
  );
endmodule

// File: rtl/xfer_mode_checker.sv
module xfer_mode_checker
  import xfer_mode_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              softReset,
  input logic              cfgWrEn,
  input logic [MODE_W-1:0] cfgWrData,
  input logic              lockWrEn,
  input logic              lockWrData,
  input logic              fifoEnable,
  input logic              xferRead,
  input logic [MODE_W-1:0] modeBits,
  input logic              lockQ,
  input logic              useFifoRd,
  input logic              useFifoWr,
  input logic              burstMode,
  input logic              fifoActive,
  input logic              perByteReq
);
  AST_HARD_CLEAR: assert property (@(posedge clk) !rstN |-> (modeBits == '0 && !lockQ)); // R1
  AST_WRITE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !softReset) |=> modeBits == $past(cfgWrData)); // R2
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (softReset && !lockQ) |=> modeBits == '0); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (softReset && lockQ) |=> $stable(modeBits)); // R4
  AST_SOFT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (softReset && cfgWrEn && !lockQ) |=> modeBits == '0); // R5
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEnable |-> (!useFifoRd && !useFifoWr && !burstMode)); // R7
  AST_DIR_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    fifoActive |-> (xferRead ? useFifoRd : useFifoWr)); // R8
  AST_PER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    !burstMode |-> perByteReq); // R9
  AST_LOCK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    lockWrEn |=> lockQ == $past(lockWrData)); // R10
endmodule

bind xfer_mode_reg xfer_mode_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .softReset  (softReset),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .lockWrEn   (lockWrEn),
  .lockWrData (lockWrData),
  .fifoEnable (fifoEnable),
  .xferRead   (xferRead),
  .modeBits   (modeQ),
  .lockQ      (lockQ),
  .useFifoRd  (useFifoRd),
  .useFifoWr  (useFifoWr),
  .burstMode  (burstMode),
  .fifoActive (fifoActive),
  .perByteReq (perByteReq)
);

// File: tb/xfer_mode_reg_test.sv
module xfer_mode_reg_test;
  logic clk = 1'b0;
  logic rstN, softReset, cfgWrEn, lockWrEn, lockWrData, fifoEnable, xferRead;
  logic [2:0] cfgWrData;
  logic useFifoRd, useFifoWr, burstMode, fifoActive, perByteReq;
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xfer_mode_reg uut (
    .clk(clk), .rstN(rstN), .softReset(softReset), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .lockWrEn(lockWrEn), .lockWrData(lockWrData),
    .fifoEnable(fifoEnable), .xferRead(xferRead), .useFifoRd(useFifoRd),
    .useFifoWr(useFifoWr), .burstMode(burstMode), .fifoActive(fifoActive),
    .perByteReq(perByteReq)
  );

  // expected outputs from a mode value: [0] burst off, [1] read bypass, [2] write bypass
  task automatic checkOut(input string req, input logic [2:0] m, input logic fe, input logic dir);
    logic eRd, eWr, eBu, eAct, ePb;
    logic [4:0] exp5, got5;
    fifoEnable = fe;
    xferRead = dir;
    #1;
    eRd = fe & ~m[1];
    eWr = fe & ~m[2];
    eBu = fe & ~m[0];
    eAct = dir ? eRd : eWr;
    ePb = ~(eAct & eBu);
    exp5 = {eRd, eWr, eBu, eAct, ePb};
    got5 = {useFifoRd, useFifoWr, burstMode, fifoActive, perByteReq};
    compared++;
    if (got5 !== exp5) begin
      mismatched++;
      $display("FAIL %s: mode=%b fe=%b rd=%b got=%b expected=%b", req, m, fe, dir, got5, exp5);
    end
  endtask

  task automatic checkAll(input string req, input logic [2:0] m);
    for (int f = 0; f < 2; f++)
      for (int d = 0; d < 2; d++)
        checkOut(req, m, f[0], d[0]);
  endtask

  task automatic writeMode(input logic [2:0] m, input logic sr);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrData = m; softReset = sr;
    @(negedge clk);
    cfgWrEn = 1'b0; softReset = 1'b0;
  endtask

  task automatic writeLock(input logic v);
    @(negedge clk);
    lockWrEn = 1'b1; lockWrData = v;
    @(negedge clk);
    lockWrEn = 1'b0;
  endtask

  task automatic pulseSoft();
    @(negedge clk);
    softReset = 1'b1;
    @(negedge clk);
    softReset = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; softReset = 0; cfgWrEn = 0; cfgWrData = 0;
    lockWrEn = 0; lockWrData = 0; fifoEnable = 1; xferRead = 1;
    repeat (3) @(negedge clk);
    checkAll("R1", 3'b000);
    rstN = 1'b1;
    // R2 R7 R8 R9: sweep every mode value
    for (int m = 0; m < 8; m++) begin
      writeMode(m[2:0], 1'b0);
      checkAll("R2_R7_R8_R9", m[2:0]);
    end
    // R7: stored bits return after queue re-enable
    writeMode(3'b101, 1'b0);
    checkOut("R7", 3'b101, 1'b0, 1'b1);
    @(negedge clk);
    checkAll("R7", 3'b101);
    // R3: unlocked soft reset clears
    writeMode(3'b111, 1'b0);
    pulseSoft();
    checkAll("R3", 3'b000);
    // R4 R10: locked soft reset holds; lock itself survives soft reset
    writeLock(1'b1);
    writeMode(3'b101, 1'b0);
    pulseSoft();
    checkAll("R4", 3'b101);
    pulseSoft();
    checkAll("R10", 3'b101);
    // R5: locked, write with soft reset is discarded
    writeMode(3'b010, 1'b1);
    checkAll("R5", 3'b101);
    // R5: unlocked, write with soft reset -> cleared
    writeLock(1'b0);
    writeMode(3'b011, 1'b0);
    writeMode(3'b110, 1'b1);
    checkAll("R5", 3'b000);
    // R6: hard reset clears lock and bits
    writeLock(1'b1);
    writeMode(3'b111, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    checkAll("R6", 3'b000);
    writeMode(3'b111, 1'b0);
    pulseSoft();
    checkAll("R6", 3'b000);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog: run did not finish, got=hung expected=done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule